// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the refresh strobes of a two-bank asynchronous DRAM array. It also runs the array's power-up routine. After reset it holds every strobe inactive for a programmable pause. It then fires a fixed number of warm-up refresh cycles on its own, with no grant needed. Only after the precharge of the last warm-up cycle does it raise `init_done_o`. Until then the access controller must issue no traffic.

After that, a free-running interval counter adds one refresh credit per period. Each credit raises `req_o`. The access controller answers with `gnt_i`, or with `hid_ok_i` at the end of a read while it still holds the column strobes low. The block then drives one refresh cycle on both bank row strobes at once, and `busy_o` tells the controller that the block owns the strobes.

The default cycle type is column-before-row refresh, with the write enable held inactive. A parameter switches to row-only refresh instead. In that mode the column strobes stay high and a 10-bit row counter is presented on the address. A second parameter enables the hidden variant, which starts from a read whose column strobes are still low.

All times are counted in clock cycles. The defaults assume an 8 ns clock: a 12500-cycle pause (100 µs) and a 1950-cycle interval (15.6 µs, so 1024 refreshes every 16 ms).

Top module: `rfsh_seq`

## Requirements
- R1: While `rst_ni` is low: all row and column strobes are high, `we_no` is high, and `req_o`, `busy_o` and `init_done_o` are 0.
- R2: After reset release, every strobe stays high for exactly PAUSE_CYC full clock cycles before the first strobe falls.
- R3: After the pause, exactly WARMUP refresh cycles run back to back without any grant. `init_done_o` rises in the cycle that follows the last precharge and then stays 1. `req_o` stays 0 while `init_done_o` is 0.
- R4: In a column-before-row cycle, all column strobes fall together T_CSR cycles before both row strobes fall together. The column strobes remain low for the whole row-low period. `we_no` is always 1.
- R5: The row strobes stay low for exactly T_RAS cycles per refresh. They then stay high for at least T_RP cycles, with all column strobes high, before any further row fall.
- R6: Once `init_done_o` is 1, a credit is added every REF_INT cycles. The first `req_o` appears REF_INT cycles after `init_done_o` rises, and later requests follow the same period whether or not a grant is delayed.
- R7: Up to MAX_PEND credits are kept and extra periods are dropped. When `gnt_i` is held high, one refresh cycle is issued per stored credit, and `req_o` then falls to 0.
- R8: A refresh cycle starts only in the cycle after `req_o` is seen together with `gnt_i` (or a hidden start). While `req_o` waits without a grant, `busy_o` stays 0. `req_o` is 0 while `busy_o` is 1.
- R9: With HIDDEN_EN=1 and RAS_ONLY=0, `hid_ok_i` high while `req_o` is 1 makes the next cycle drive the column strobes low and the row strobes high. This lasts T_RP cycles. T_RAS row-low cycles follow, with the column strobes still low, and then the normal precharge.
- R10: When RAS_ONLY=1 (or HIDDEN_EN=0), `hid_ok_i` has no effect: `busy_o` stays 0 and `req_o` stays 1.
- R11: With RAS_ONLY=1, the column strobes never fall. `addr_o` holds the row counter, stable for the whole row-low period and the cycle after it. The counter starts at 0, advances by one after each refresh (warm-up cycles included) and wraps from 2^ROW_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Grant from the access controller |
| hid_ok_i | input | 1 | Read just ended with column strobes held low; hidden start allowed |
| req_o | output | 1 | Refresh credit pending, block idle |
| busy_o | output | 1 | Block owns the strobes |
| init_done_o | output | 1 | Power-up routine finished |
| ras_no | output | NB | Row strobes, one per bank, active low |
| cas_no | output | NC | Column strobes, one per byte lane, active low |
| we_no | output | 1 | Write enable, held inactive |
| addr_o | output | ROW_W | Refresh row address |

## Verification
A wrong phase counter shows up as a row pulse, precharge or setup window whose length is off. This is visible at the strobes within one refresh cycle, about 15 clocks. A stuck warm-up count or a missed init flag shows as the wrong number of row falls before `init_done_o`, or as a request during power-up, within about 120 clocks of the pause ending. Credit or row counter faults take longer to appear. They surface as a request period that is not REF_INT, as a burst length that is not MAX_PEND, or as an out-of-order row address on the very next row fall in row-only mode.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CSU,   // column low, row high: setup before row fall
    ST_ACT,   // row low
    ST_PRE,   // row and column high
    ST_HPRE   // hidden start: column held low, row precharging
  } rfsh_state_e;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CW'(RST_VAL);
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
  parameter int REF_INT  = 1950,
  parameter int MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic take_i,
  output logic pend_o
);
  localparam int IW = $clog2(REF_INT + 1);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [IW-1:0] ivl_q;
  logic [PW-1:0] cred_q;
  logic          tick, full, inc;

  assign tick = en_i && (ivl_q == IW'(REF_INT - 1));
  assign full = (cred_q == PW'(MAX_PEND));
  assign inc  = tick && (!full || take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ivl_q <= '0;
    else if (tick) ivl_q <= '0;
    else if (en_i) ivl_q <= ivl_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cred_q <= '0;
    else begin
      case ({inc, take_i})
        2'b10:   cred_q <= cred_q + 1'b1;
        2'b01:   cred_q <= cred_q - 1'b1;
        default: cred_q <= cred_q;
      endcase
    end
  end

  assign pend_o = (cred_q != '0);
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (inc_i) row_o <= row_o + 1'b1;
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int NB        = 2,
  parameter int NC        = 4,
  parameter int ROW_W     = 10,
  parameter int PAUSE_CYC = 12500,
  parameter int WARMUP    = 8,
  parameter int REF_INT   = 1950,
  parameter int MAX_PEND  = 8,
  parameter int T_CSR     = 1,
  parameter int T_RAS     = 9,
  parameter int T_RP      = 5,
  parameter bit RAS_ONLY  = 1'b0,
  parameter bit HIDDEN_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_i,
  input  logic             hid_ok_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             init_done_o,
  output logic [NB-1:0]    ras_no,
  output logic [NC-1:0]    cas_no,
  output logic             we_no,
  output logic [ROW_W-1:0] addr_o
);
  localparam int TM1  = (PAUSE_CYC > T_RAS) ? PAUSE_CYC : T_RAS;
  localparam int TM2  = (T_RP > T_CSR) ? T_RP : T_CSR;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int WW   = $clog2(WARMUP + 1);
  localparam bit HID_ON = HIDDEN_EN && !RAS_ONLY;
  localparam rfsh_state_e START_ST = RAS_ONLY ? ST_ACT : ST_CSU;
  localparam logic [CW-1:0] START_VAL = RAS_ONLY ? CW'(T_RAS - 1) : CW'(T_CSR - 1);

  rfsh_state_e   state_q, state_d;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic [WW-1:0] wup_q;
  logic          wup_inc, init_set, init_q;
  logic          take, pend, row_inc, hid_go;
  logic          ras_low, cas_low;

  rfsh_timer #(.CW(CW), .RST_VAL(PAUSE_CYC)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  rfsh_credit #(.REF_INT(REF_INT), .MAX_PEND(MAX_PEND)) u_cred (
    .clk_i, .rst_ni, .en_i(init_q), .take_i(take), .pend_o(pend)
  );

  rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i, .rst_ni, .inc_i(row_inc), .row_o(addr_o)
  );

  assign req_o  = init_q && pend && (state_q == ST_IDLE);
  assign hid_go = HID_ON && req_o && hid_ok_i;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take     = 1'b0;
    wup_inc  = 1'b0;
    init_set = 1'b0;
    row_inc  = 1'b0;
    unique case (state_q)
      ST_PAUSE: if (tmr_done) begin
        state_d = START_ST; tmr_load = 1'b1; tmr_val = START_VAL;
      end
      ST_IDLE: begin
        if (hid_go) begin
          state_d = ST_HPRE; tmr_load = 1'b1; tmr_val = CW'(T_RP - 1); take = 1'b1;
        end else if (req_o && gnt_i) begin
          state_d = START_ST; tmr_load = 1'b1; tmr_val = START_VAL; take = 1'b1;
        end
      end
      ST_CSU, ST_HPRE: if (tmr_done) begin
        state_d = ST_ACT; tmr_load = 1'b1; tmr_val = CW'(T_RAS - 1);
      end
      ST_ACT: if (tmr_done) begin
        state_d = ST_PRE; tmr_load = 1'b1; tmr_val = CW'(T_RP - 1);
      end
      ST_PRE: if (tmr_done) begin
        row_inc = 1'b1;  // row moves only after precharge: address hold met
        if (!init_q) begin
          wup_inc = 1'b1;
          if (wup_q == WW'(WARMUP - 1)) begin
            init_set = 1'b1; state_d = ST_IDLE;
          end else begin
            state_d = START_ST; tmr_load = 1'b1; tmr_val = START_VAL;
          end
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      wup_q   <= '0;
      init_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wup_inc)  wup_q  <= wup_q + 1'b1;
      if (init_set) init_q <= 1'b1;
    end
  end

  assign ras_low = (state_q == ST_ACT);

  if (RAS_ONLY) begin : g_row_only
    assign cas_low = 1'b0;
  end else begin : g_cbr
    assign cas_low = (state_q == ST_CSU) || (state_q == ST_ACT) || (state_q == ST_HPRE);
  end

  assign ras_no      = {NB{~ras_low}};
  assign cas_no      = {NC{~cas_low}};
  assign we_no       = 1'b1;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_PAUSE);
  assign init_done_o = init_q;
endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
  parameter int NB        = 2,
  parameter int NC        = 4,
  parameter int ROW_W     = 10,
  parameter int T_CSR     = 1,
  parameter int T_RAS     = 9,
  parameter int T_RP      = 5,
  parameter bit RAS_ONLY  = 1'b0,
  parameter bit HIDDEN_EN = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gnt_i,
  input logic             hid_ok_i,
  input logic             req_o,
  input logic             busy_o,
  input logic             init_done_o,
  input logic [NB-1:0]    ras_no,
  input logic [NC-1:0]    cas_no,
  input logic [ROW_W-1:0] addr_o
);
  logic [15:0] low_cnt, high_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else if (!ras_no[0]) begin
      high_cnt <= '0;
      if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
      if (high_cnt != '1) high_cnt <= high_cnt + 1'b1;
    end
  end

  p_cas_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!RAS_ONLY && $fell(ras_no[0])) |-> (cas_no == '0 && $past(cas_no) == '0));

  p_ras_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no[0]) |-> (low_cnt == 16'(T_RAS) && cas_no == '1));

  p_precharge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no[0]) |-> (high_cnt >= 16'(T_RP)));

  p_no_req_init_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !req_o);

  p_init_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  p_start_granted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && init_done_o) |-> $past(req_o && (gnt_i || hid_ok_i)));

  p_req_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_o);

  p_hidden_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HIDDEN_EN && !RAS_ONLY && req_o && hid_ok_i) |=> (cas_no == '0 && ras_no == '1 && busy_o));

  p_hidden_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!HIDDEN_EN || RAS_ONLY) && req_o && hid_ok_i && !gnt_i) |=> (!busy_o && req_o));

  p_rowonly_cas_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RAS_ONLY && !ras_no[0]) |-> (cas_no == '1));

  p_addr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RAS_ONLY && ((!ras_no[0] && $past(!ras_no[0])) || $rose(ras_no[0]))) |-> $stable(addr_o));
endmodule

bind rfsh_seq rfsh_seq_chk #(
  .NB(NB), .NC(NC), .ROW_W(ROW_W), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
  .RAS_ONLY(RAS_ONLY), .HIDDEN_EN(HIDDEN_EN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gnt_i(gnt_i), .hid_ok_i(hid_ok_i),
  .req_o(req_o), .busy_o(busy_o), .init_done_o(init_done_o),
  .ras_no(ras_no), .cas_no(cas_no), .addr_o(addr_o)
);

// File: tb/sim_rfsh_seq.sv
module sim_rfsh_seq;
  localparam int PAUSE = 12500, WUP = 8, RINT = 1950, MAXP = 8;
  localparam int TCSR = 1, TRAS = 9, TRP = 5;
  localparam int CYC_LEN = TCSR + TRAS + TRP;
  // one granted column-before-row cycle, per sample: {row low, column low, busy}
  localparam logic [2:0] CBR_TBL [16] = '{
    3'b011,
    3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111,
    3'b001, 3'b001, 3'b001, 3'b001, 3'b001,
    3'b000};

  logic clk = 1'b0, rst_n = 1'b0;
  logic gnt0 = 1'b0, hid0 = 1'b0, gnt1 = 1'b0, hid1 = 1'b0;
  logic req0, busy0, idn0, we0, req1, busy1, idn1, we1;
  logic [1:0] ras0, ras1;
  logic [3:0] cas0, cas1;
  logic [9:0] addr0, addr1;
  int checks = 0, errors = 0, cyc = 0;
  bit done0 = 0, done1 = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rfsh_seq #(.PAUSE_CYC(PAUSE), .WARMUP(WUP), .REF_INT(RINT), .MAX_PEND(MAXP),
             .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt0), .hid_ok_i(hid0), .req_o(req0),
    .busy_o(busy0), .init_done_o(idn0), .ras_no(ras0), .cas_no(cas0), .we_no(we0),
    .addr_o(addr0));

  rfsh_seq #(.PAUSE_CYC(20), .WARMUP(WUP), .REF_INT(20), .MAX_PEND(2),
             .RAS_ONLY(1'b1), .HIDDEN_EN(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt1), .hid_ok_i(hid1), .req_o(req1),
    .busy_o(busy1), .init_done_o(idn1), .ras_no(ras1), .cas_no(cas1), .we_no(we1),
    .addr_o(addr1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) if (cyc == 190000) begin
    chk(1'b0, "watchdog", cyc, 0);
    summary();
    $finish;
  end

  // row-only instance monitor (R11)
  logic [9:0] exp_row = '0, held1 = '0;
  logic       prev1 = 1'b1;
  int         falls1 = 0;
  bit         wrap1 = 0;
  always @(negedge clk) if (rst_n) begin
    if (prev1 && ras1 == 2'b00) begin
      chk(addr1 == exp_row, "R11 row address at fall", addr1, exp_row);
      if (addr1 == 10'd0 && falls1 > 1000) wrap1 = 1;
      held1 = addr1;
      exp_row = exp_row + 1'b1;
      falls1++;
    end
    if (ras1 == 2'b00 || prev1 == 1'b0) begin
      chk(addr1 == held1, "R11 address stable in row pulse", addr1, held1);
      chk(cas1 == 4'hF, "R11 column strobes high", cas1, 15);
    end
    prev1 = ras1[0];
  end

  initial begin : t_u1
    @(posedge rst_n);
    wait (idn1 && req1);
    @(negedge clk);
    hid1 = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy1 && req1, "R10 hidden request ignored in row-only mode", {busy1, req1}, 1);
    end
    hid1 = 1'b0;
    gnt1 = 1'b1;
    wait (falls1 >= 1030);
    @(negedge clk);
    chk(wrap1, "R11 row counter wraps to 0", wrap1, 1);
    chk(we1 == 1'b1, "R4 write enable inactive (row-only)", we1, 1);
    gnt1 = 1'b0;
    done1 = 1;
  end

  initial begin : t_u0
    int n, m, f, t1, t2;
    logic pr;
    repeat (3) @(negedge clk);
    chk(ras0 == 2'b11 && cas0 == 4'hF && we0, "R1 strobes idle in reset", {ras0, cas0, we0}, 127);
    chk(!req0 && !busy0 && !idn0, "R1 flags low in reset", {req0, busy0, idn0}, 0);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      if (cas0 == 4'hF && ras0 == 2'b11) n++;
    end while (cas0 == 4'hF && ras0 == 2'b11);
    chk(n == PAUSE, "R2 power-up pause length", n, PAUSE);

    // warm-up phase
    m = 1; f = 0; pr = ras0[0];
    while (!idn0) begin
      @(negedge clk);
      m++;
      if (pr && !ras0[0]) f++;
      pr = ras0[0];
      if (req0) chk(1'b0, "R3 request during warm-up", 1, 0);
    end
    chk(f == WUP, "R3 warm-up cycle count", f, WUP);
    chk(m == WUP * CYC_LEN + 1, "R3 init_done after last precharge", m, WUP * CYC_LEN + 1);
    chk(ras0 == 2'b11 && cas0 == 4'hF && !busy0, "R3 idle when init done", {ras0, cas0}, 63);

    // first interval
    n = 0;
    while (!req0) begin @(negedge clk); n++; end
    chk(n == RINT, "R6 first request delay", n, RINT);
    t1 = cyc;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy0 && req0, "R8 no start without grant", {busy0, req0}, 1);
    end

    // granted column-before-row cycle, walked from the table
    gnt0 = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 0) gnt0 = 1'b0;
      chk({ras0 == 2'b00, cas0 == 4'h0, busy0} == CBR_TBL[k] &&
          (ras0 == 2'b00 || ras0 == 2'b11) && (cas0 == 4'h0 || cas0 == 4'hF),
          "R4 R5 R8 cycle shape", {ras0, cas0, busy0}, CBR_TBL[k]);
      chk(we0 && !req0, "R4 write enable high, R8 no request", {we0, req0}, 2);
    end

    // period independent of grant delay
    while (!req0) @(negedge clk);
    t2 = cyc;
    chk(t2 - t1 == RINT, "R6 request period", t2 - t1, RINT);
    gnt0 = 1'b1;
    @(negedge clk);
    gnt0 = 1'b0;

    // saturate credits, then drain
    while (cyc < t2 + 10 * RINT + 100) @(negedge clk);
    chk(req0 && !busy0, "R7 request held while waiting", {req0, busy0}, 2);
    gnt0 = 1'b1;
    f = 0; pr = ras0[0];
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (pr && !ras0[0]) f++;
      pr = ras0[0];
    end
    gnt0 = 1'b0;
    chk(f == MAXP, "R7 burst length equals stored credits", f, MAXP);
    chk(!req0 && !busy0, "R7 request drops after burst", {req0, busy0}, 0);

    // hidden refresh start
    while (!req0) @(negedge clk);
    hid0 = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      logic er, ec, eb;
      @(negedge clk);
      hid0 = 1'b0;
      er = (k >= 6 && k <= 14);
      ec = (k <= 14);
      eb = (k <= 19);
      chk({ras0 == 2'b00, cas0 == 4'h0, busy0} == {er, ec, eb}, "R9 hidden cycle shape",
          {ras0 == 2'b00, cas0 == 4'h0, busy0}, {er, ec, eb});
    end
    done0 = 1;
  end

  initial begin
    wait (done0 && done1);
    summary();
    $finish;
  end
endmodule